// File: doc/BRIEF.md
# Shadow RAM Word Writer with Flush Sequencer

This block holds a fixed-size 16-bit-word shadow memory that stands in for a small nonvolatile store. The host posts one word at a time through a 32-bit command register: a start flag, a word address and sixteen data bits travel in the same write. The block stores the word and raises a completion flag that the host polls. Byte updates are the host's job: it reads the containing word, merges the byte and posts the whole word back.

Nothing reaches the nonvolatile side until the host sets the update-request bit of a separate control register. The sequencer then reads every word of the shadow memory in ascending order and presents each on a simple one-word-per-cycle program port. When the last word has gone out, the request bit drops by itself and an update-complete bit is raised. A one-bit-per-word written map makes every word the host has never written read as the erased value 0xFFFF, so the whole memory behaves as one erase unit that reset returns to the erased state.

Top module: `shadow_flush_ctrl`

## Requirements
- R1: A command-register write with bit 0 set stores bits 31:16 at the word address in bits 12:2; bit 1 of the command readback (done) is 1 from the second rising edge after that write and stays 1 until the next command with bit 0 set.
- R2: A command-register write with bit 0 clear has no effect: done keeps its value and no word changes.
- R3: The rising edge that accepts a command with bit 0 set clears done, and readback bit 0 reads 1 while that command waits to be stored.
- R4: Command readback bits 12:2 and 31:16 return the address and data of the last accepted command.
- R5: A word never written since reset is copied out as 0xFFFF, and reset returns every word to that erased value.
- R6: Writing the control register with bit 23 set while no update runs starts an update; from the next rising edge bit 23 reads 1 and bit 26 reads 0.
- R7: An update emits exactly one program-port write per word, on consecutive cycles, starting at address 0 and ascending by one.
- R8: When the update ends, bit 23 falls and bit 26 rises on the same edge; bit 26 is never 1 while bit 23 is 1 and stays 1 until the next update starts.
- R9: A command accepted during an update is not stored until the update ends (so that update copies the old word), and done stays 0 until it is stored.
- R10: Control-register writes while an update runs, or with bit 23 clear, have no effect.
- R11: After reset, done, readback bit 0, control bits 23 and 26 and the program-port write strobe are all 0.
- R12: When the same address is written twice, the later data is the one copied out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word: bit 0 start, bits 12:2 word address, bits 31:16 data |
| cmd_rdata | output | 32 | Command readback: bit 0 pending, bit 1 done, address and data of last command |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 32 | Control word: bit 23 requests an update |
| ctl_rdata | output | 32 | Control readback: bit 23 update running, bit 26 update complete |
| nv_we | output | 1 | Program-port write strobe, one cycle per word |
| nv_addr | output | 11 | Program-port word address |
| nv_wdata | output | 16 | Program-port word data |

## Verification
On every cycle the assertions check that program-port writes occur only while an update runs, begin at address 0 and step by one, that the running and complete bits never coexist and hand over on one edge, that an accepted command clears done and that done only rises outside an update. Only the bench's scenarios can show the data itself: that each stored word, overwrite and ignored command is reflected in the copied image, that never-written words and a reset give 0xFFFF, and that a command held off during an update is missing from that update's copy but present in the next.

// File: rtl/shflush_pkg.sv
// Package: field positions and shared types for the shadow RAM flush block.
// Assumes a 32-bit host register width and 16-bit storage words.
package shflush_pkg;
    localparam int DATA_W           = 16;
    localparam int REG_W            = 32;
    localparam int CMD_VALID_BIT    = 0;
    localparam int CMD_DONE_BIT     = 1;
    localparam int CMD_ADDR_LSB     = 2;
    localparam int CMD_DATA_LSB     = 16;
    localparam int CTL_UPD_BIT      = 23;
    localparam int CTL_UPD_DONE_BIT = 26;
    localparam logic [DATA_W-1:0] ERASED_WORD = '1;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_RUN   = 2'd1,
        FL_DRAIN = 2'd2
    } flush_state_t;
endpackage

// File: rtl/shflush_cmd_port.sv
// Module: command register decode. Captures a word command when the start
// bit is set, holds it pending while an update runs, then issues one store
// and raises done. Assumes the address field fits below the data field.
module shflush_cmd_port
    import shflush_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [REG_W-1:0]  cmd_wdata,
    input  logic              flush_busy,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              pending,
    output logic              done
);
    logic              accept;
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] data_q;
    logic              unused_cmd_bits;

    // Purpose: detect a host write that carries the start bit.
    assign accept = cmd_we && cmd_wdata[CMD_VALID_BIT];

    // Purpose: mark the bits of the command word this module does not decode.
    assign unused_cmd_bits = ^{cmd_wdata[CMD_DONE_BIT], cmd_wdata[CMD_DATA_LSB-1:CMD_ADDR_LSB]};

    // Purpose: a pending command may be stored only when no update reads memory.
    assign mem_we    = pending && !flush_busy;
    assign mem_waddr = addr_q;
    assign mem_wdata = data_q;

    // Purpose: hold the last command and track its pending and done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            done    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (accept) begin
            pending <= 1'b1;
            done    <= 1'b0;
            addr_q  <= cmd_wdata[CMD_ADDR_LSB +: AW];
            data_q  <= cmd_wdata[CMD_DATA_LSB +: DATA_W];
        end else if (mem_we) begin
            pending <= 1'b0;
            done    <= 1'b1;
        end
    end
endmodule

// File: rtl/shflush_store.sv
// Module: shadow word memory with a per-word written map. Words never written
// since reset read back as the erased value. One write port and one
// registered read port; a read in the same cycle as a write to the same
// word returns the previous content (the controller never does both).
module shflush_store
    import shflush_pkg::*;
#(
    parameter int WORDS = 2048,
    parameter int AW    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  written;

    // Purpose: store the word (array without reset, as a RAM macro would be).
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Purpose: record which words hold host data; reset erases them all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written <= '0;
        end else if (we) begin
            written[waddr] <= 1'b1;
        end
    end

    // Purpose: registered read, substituting the erased value for unwritten words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= ERASED_WORD;
        end else begin
            rdata <= written[raddr] ? mem[raddr] : ERASED_WORD;
        end
    end
endmodule

// File: rtl/shflush_seq.sv
// Module: update sequencer. On a start request while idle it walks every
// word address from 0 upward, one per cycle, and drives each word onto the
// program port one cycle later (memory read latency). Assumes the program
// port accepts a word every cycle.
module shflush_seq
    import shflush_pkg::*;
#(
    parameter int WORDS = 2048,
    parameter int AW    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     raddr,
    output logic              busy,
    output logic              upd_done,
    output logic              nv_we,
    output logic [AW-1:0]     nv_addr,
    output logic [DATA_W-1:0] nv_wdata
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(WORDS - 1);

    flush_state_t  state;
    logic [AW-1:0] cnt;
    logic          issue_v;
    logic [AW-1:0] issue_addr;

    // Purpose: expose the walk counter as the memory read address.
    assign raddr = cnt;
    assign busy  = (state != FL_IDLE);

    // Purpose: program port follows the read issued one cycle earlier.
    assign nv_we    = issue_v;
    assign nv_addr  = issue_addr;
    assign nv_wdata = rdata;

    // Purpose: state machine stepping the address walk and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= FL_IDLE;
            cnt        <= '0;
            issue_v    <= 1'b0;
            issue_addr <= '0;
            upd_done   <= 1'b0;
        end else begin
            unique case (state)
                FL_IDLE: begin
                    issue_v <= 1'b0;
                    if (start_req) begin
                        state    <= FL_RUN;
                        cnt      <= '0;
                        upd_done <= 1'b0;
                    end
                end
                FL_RUN: begin
                    issue_v    <= 1'b1;
                    issue_addr <= cnt;
                    cnt        <= cnt + 1'b1;
                    if (cnt == LAST_ADDR) begin
                        state <= FL_DRAIN;
                    end
                end
                FL_DRAIN: begin
                    issue_v  <= 1'b0;
                    state    <= FL_IDLE;
                    upd_done <= 1'b1;
                end
                default: begin
                    state   <= FL_IDLE;
                    issue_v <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/shadow_flush_ctrl.sv
// Module: top of the shadow RAM word writer. Joins the command decode, the
// shadow store and the update sequencer, and assembles both readback words.
// Assumes WORDS is a power of two no larger than 16384 so the address fits
// in command bits 15:2.
module shadow_flush_ctrl
    import shflush_pkg::*;
#(
    parameter int WORDS = 2048,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [REG_W-1:0]  cmd_wdata,
    output logic [REG_W-1:0]  cmd_rdata,
    input  logic              ctl_we,
    input  logic [REG_W-1:0]  ctl_wdata,
    output logic [REG_W-1:0]  ctl_rdata,
    output logic              nv_we,
    output logic [AW-1:0]     nv_addr,
    output logic [DATA_W-1:0] nv_wdata
);
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [AW-1:0]     mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              pending;
    logic              done;
    logic              busy;
    logic              upd_done;
    logic              start_req;
    logic              unused_ctl_bits;

    // Purpose: an update request is honoured only while idle.
    assign start_req       = ctl_we && ctl_wdata[CTL_UPD_BIT] && !busy;
    assign unused_ctl_bits = ^ctl_wdata;

    shflush_cmd_port #(.AW(AW)) cmd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_wdata  (cmd_wdata),
        .flush_busy (busy),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .pending    (pending),
        .done       (done)
    );

    shflush_store #(.WORDS(WORDS), .AW(AW)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    shflush_seq #(.WORDS(WORDS), .AW(AW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .rdata     (mem_rdata),
        .raddr     (mem_raddr),
        .busy      (busy),
        .upd_done  (upd_done),
        .nv_we     (nv_we),
        .nv_addr   (nv_addr),
        .nv_wdata  (nv_wdata)
    );

    // Purpose: build the command readback from the held command and its flags.
    always_comb begin
        cmd_rdata                          = '0;
        cmd_rdata[CMD_VALID_BIT]           = pending;
        cmd_rdata[CMD_DONE_BIT]            = done;
        cmd_rdata[CMD_ADDR_LSB +: AW]      = mem_waddr;
        cmd_rdata[CMD_DATA_LSB +: DATA_W]  = mem_wdata;
    end

    // Purpose: build the control readback from the sequencer flags.
    always_comb begin
        ctl_rdata                   = '0;
        ctl_rdata[CTL_UPD_BIT]      = busy;
        ctl_rdata[CTL_UPD_DONE_BIT] = upd_done;
    end
endmodule

// File: rtl/shadow_flush_ctrl_chk.sv
// Module: assertion checker bound to shadow_flush_ctrl. Observes ports only.
module shadow_flush_ctrl_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_we,
    input logic          cmd_valid,
    input logic          cmd_done,
    input logic          ctl_we,
    input logic          ctl_req,
    input logic          busy,
    input logic          upd_done,
    input logic          nv_we,
    input logic [AW-1:0] nv_addr
);
    // R7: program writes only during an update
    assert_nv_in_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> busy);

    // R7: consecutive program writes step by one
    assert_nv_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_we && $past(nv_we)) |-> (nv_addr == $past(nv_addr) + 1'b1));

    // R7: each burst begins at word 0
    assert_nv_first_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_we) |-> (nv_addr == '0));

    // R8: running and complete never together
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && upd_done));

    // R8: completion raised on the edge the update ends
    assert_finish_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> upd_done);

    // R6: accepted request starts an update and clears completion
    assert_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_req && !busy) |=> (busy && !upd_done));

    // R3: accepted command clears done
    assert_cmd_clears_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_valid) |=> !cmd_done);

    // R1: done holds until a new command
    assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !(cmd_we && cmd_valid)) |=> cmd_done);

    // R9: done never rises out of an update cycle
    assert_hold_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> !$past(busy));
endmodule

bind shadow_flush_ctrl shadow_flush_ctrl_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .cmd_valid (cmd_wdata[shflush_pkg::CMD_VALID_BIT]),
    .cmd_done  (cmd_rdata[shflush_pkg::CMD_DONE_BIT]),
    .ctl_we    (ctl_we),
    .ctl_req   (ctl_wdata[shflush_pkg::CTL_UPD_BIT]),
    .busy      (ctl_rdata[shflush_pkg::CTL_UPD_BIT]),
    .upd_done  (ctl_rdata[shflush_pkg::CTL_UPD_DONE_BIT]),
    .nv_we     (nv_we),
    .nv_addr   (nv_addr)
);

// File: tb/shadow_flush_ctrl_tb_top.sv
module shadow_flush_ctrl_tb_top;
    localparam int WORDS = 2048;
    localparam int AW    = 11;
    localparam int NVEC  = 8;
    // {start bit, word address, data}
    localparam logic [27:0] VEC [NVEC] = '{
        {1'b1, 11'd0,    16'h1234},
        {1'b1, 11'd1,    16'hA55A},
        {1'b1, 11'd2047, 16'hC0DE},
        {1'b1, 11'd5,    16'h0F0F},
        {1'b1, 11'd5,    16'h7E57},
        {1'b0, 11'd100,  16'hDEAD},
        {1'b1, 11'd1024, 16'h0000},
        {1'b1, 11'd6,    16'hAB12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [31:0]   cmd_wdata = '0;
    logic [31:0]   cmd_rdata;
    logic          ctl_we = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic [31:0]   ctl_rdata;
    logic          nv_we;
    logic [AW-1:0] nv_addr;
    logic [15:0]   nv_wdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] model  [WORDS];
    logic [15:0] nv_img [WORDS];
    int nv_cnt = 0;
    int nv_order_bad = 0;
    int nv_next = 0;

    always #10 clk = ~clk;

    shadow_flush_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata)
    );

    // Program-port model: capture each word away from the active edge.
    always @(negedge clk) begin
        if (nv_we) begin
            if (int'(nv_addr) != nv_next) nv_order_bad++;
            nv_img[nv_addr] = nv_wdata;
            nv_next = int'(nv_addr) + 1;
            nv_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic post_cmd(input logic valid, input logic [10:0] a, input logic [15:0] d);
        cmd_wdata = {d, 3'b000, a, 1'b0, valid};
        cmd_we    = 1'b1;
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    // Runs one update, optionally posting a command and a second request mid-way.
    task automatic run_flush(input bit hold, input logic [10:0] ha, input logic [15:0] hd);
        int cyc;
        nv_cnt = 0; nv_order_bad = 0; nv_next = 0;
        ctl_wdata = 32'h0080_0000;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R6 running bit after request", 32'(ctl_rdata[23]), 32'd1);
        check("R6 complete bit cleared at start", 32'(ctl_rdata[26]), 32'd0);
        cyc = 0;
        while (ctl_rdata[23] === 1'b1 && cyc < 5000) begin
            check("R8 complete bit low while running", 32'(ctl_rdata[26]), 32'd0);
            if (hold && cyc == 2) begin
                cmd_wdata = {hd, 3'b000, ha, 1'b0, 1'b1};
                cmd_we = 1'b1;
            end else if (hold && cyc == 6) begin
                cmd_we = 1'b0;
                ctl_wdata = 32'h0080_0000;
                ctl_we = 1'b1;
            end else begin
                cmd_we = 1'b0;
                ctl_we = 1'b0;
            end
            if (hold && cyc > 3)
                check("R9 done held low during update", 32'(cmd_rdata[1]), 32'd0);
            @(negedge clk);
            cyc++;
        end
        check("R8 complete bit set when running bit falls", 32'(ctl_rdata[26]), 32'd1);
        check("R7 one program write per word", nv_cnt, WORDS);
        check("R7 ascending from zero", nv_order_bad, 0);
        for (int i = 0; i < WORDS; i++)
            check($sformatf("R5/R12 copied word %0d", i), 32'(nv_img[i]), 32'(model[i]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic exp_done;
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 done after reset", 32'(cmd_rdata[1]), 32'd0);
        check("R11 pending after reset", 32'(cmd_rdata[0]), 32'd0);
        check("R11 control after reset", ctl_rdata & 32'h0480_0000, 32'd0);
        check("R11 program strobe after reset", 32'(nv_we), 32'd0);
        // R10: request bit clear while idle does nothing
        ctl_wdata = 32'hFF7F_FFFF; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R10 clear request ignored", ctl_rdata & 32'h0480_0000, 32'd0);

        exp_done = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            post_cmd(VEC[v][27], VEC[v][26:16], VEC[v][15:0]);
            if (VEC[v][27]) begin
                check("R3 done cleared on accept", 32'(cmd_rdata[1]), 32'd0);
                check("R3 pending while waiting", 32'(cmd_rdata[0]), 32'd1);
                @(negedge clk);
                check("R1 done on second edge", 32'(cmd_rdata[1]), 32'd1);
                check("R4 address readback", 32'(cmd_rdata[12:2]), 32'(VEC[v][26:16]));
                check("R4 data readback", 32'(cmd_rdata[31:16]), 32'(VEC[v][15:0]));
                model[VEC[v][26:16]] = VEC[v][15:0];
                exp_done = 1'b1;
            end else begin
                @(negedge clk);
                check("R2 ignored command keeps done", 32'(cmd_rdata[1]), 32'(exp_done));
                check("R2 ignored command keeps readback", 32'(cmd_rdata[31:16]), 32'(VEC[v-1][15:0]));
            end
        end

        run_flush(1'b0, '0, '0);
        // R10/R9: held command and a repeated request during the update
        run_flush(1'b1, 11'd9, 16'hBEEF);
        check("R9 done still low right after update", 32'(cmd_rdata[1]), 32'd0);
        @(negedge clk);
        check("R9 held command lands after update", 32'(cmd_rdata[1]), 32'd1);
        model[9] = 16'hBEEF;
        check("R8 complete bit stays set", 32'(ctl_rdata[26]), 32'd1);
        run_flush(1'b0, '0, '0);

        // R5: reset erases everything
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 control after second reset", ctl_rdata & 32'h0480_0000, 32'd0);
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        run_flush(1'b0, '0, '0);
        summary();
    end
endmodule